// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit resolves conditional program-flow instructions for a 16-bit processor core. The execute stage hands it an instruction word, the four condition flags (negative, zero, overflow, carry), the program counter already advanced past the instruction, and the value read from the register file. One clock later the unit reports whether control transfers and, if so, to which address.

Two instruction families are handled. The first is the short relative jump. Its upper byte chooses one of fifteen tests: always, a single flag, a signed comparison, or an unsigned comparison. Its lower byte is a signed word displacement. The second is a loop-count form. It decrements a register named inside the word, hands the decremented value back for write-back, and jumps backwards while that value is not zero. Any other instruction word leaves the unit quiet.

The reset input is asynchronous and active-low. It is released into the clock domain through a two-stage synchronizer. Results are registered, so every answer appears exactly one cycle after its request.

Top module: `branch_unit`

## Requirements
- R1: While reset is asserted, and after its release until the first accepted request, `res_valid`, `br_taken` and `wb_en` are all low.
- R2: A request presented with `req_valid` high yields `res_valid` high on the next cycle. A cycle without a request yields `res_valid`, `br_taken` and `wb_en` low on the next cycle.
- R3: For a relative jump that is taken, `br_target` equals `next_pc` plus twice the sign-extended `instr[7:0]`, modulo 2^16. This gives a reach of -128 to +127 words.
- R4: Flag tests are selected by upper byte as follows: 0x01 always, 0x02 when Z=0, 0x03 when Z=1, 0x80 when N=0, 0x81 when N=1, 0x84 when V=0, 0x85 when V=1, 0x86 when C=0, 0x87 when C=1. The flags input is packed as {N,Z,V,C} in bits 3..0.
- R5: Signed tests are selected by upper byte as follows: 0x04 is taken when N^V=0; 0x05 when N^V=1; 0x06 when Z|(N^V)=0; 0x07 when Z|(N^V)=1.
- R6: Unsigned tests are selected by upper byte as follows: 0x82 is taken when C|Z=0, and 0x83 when C|Z=1. The higher-or-same and lower tests are codes 0x86 and 0x87 of R4.
- R7: A loop-count word has bits 15..9 equal to 0111111. For such a word the unit raises `wb_en`, sets `wb_idx` to `instr[8:6]`, and sets `wb_data` to `reg_rdata - 1` modulo 2^16.
- R8: A loop-count word is taken exactly when `reg_rdata - 1` is not zero. Its target is `next_pc` minus twice the unsigned `instr[5:0]`.
- R9: Every other upper byte leaves `br_taken` and `wb_en` low.
- R10: The loop-count form and the unconditional jump (0x01) ignore the flags: their outcome is the same for all sixteen flag values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe for this cycle |
| instr | input | 16 | Instruction word |
| flags | input | 4 | Condition flags {N,Z,V,C} |
| next_pc | input | 16 | Program counter past the instruction |
| reg_rdata | input | 16 | Register value for the loop-count form |
| res_valid | output | 1 | Result present this cycle |
| br_taken | output | 1 | Control transfers |
| br_target | output | 16 | Destination address, meaningful when taken |
| wb_en | output | 1 | Register write-back request |
| wb_idx | output | 3 | Register index for write-back |
| wb_data | output | 16 | Decremented register value |

## Verification
The loop-count form is the one case where the branch decision and the register write-back occur in the same result cycle. The decision is also a function of the value being written back. The bench sweeps every 6-bit displacement against register values of 0, 1, 2, 3, 0x8000 and 0xFFFF. This covers both the value 1 case, which writes back zero and does not jump, and the value 0 case, which wraps to 0xFFFF and jumps. In each case the bench compares the written value, the register index, the taken bit and the backward target against figures it computes arithmetically from the request.

// File: rtl/branch_pkg.sv
package branch_pkg;

  typedef struct packed {
    logic neg;
    logic zer;
    logic ovf;
    logic cry;
  } cc_t;

  localparam logic [7:0] OP_ALWAYS = 8'h01;
  localparam logic [7:0] OP_NE     = 8'h02;
  localparam logic [7:0] OP_EQ     = 8'h03;
  localparam logic [7:0] OP_GE     = 8'h04;
  localparam logic [7:0] OP_LT     = 8'h05;
  localparam logic [7:0] OP_GT     = 8'h06;
  localparam logic [7:0] OP_LE     = 8'h07;
  localparam logic [7:0] OP_PL     = 8'h80;
  localparam logic [7:0] OP_MI     = 8'h81;
  localparam logic [7:0] OP_HI     = 8'h82;
  localparam logic [7:0] OP_LOS    = 8'h83;
  localparam logic [7:0] OP_VC     = 8'h84;
  localparam logic [7:0] OP_VS     = 8'h85;
  localparam logic [7:0] OP_CC     = 8'h86;
  localparam logic [7:0] OP_CS     = 8'h87;

  localparam logic [6:0] LOOP_PREFIX = 7'b0111111;

endpackage

// File: rtl/branch_cond.sv
module branch_cond
  import branch_pkg::*;
(
  input  logic [7:0] op_hi,
  input  cc_t        cc,
  output logic       is_loop,
  output logic       is_rel,
  output logic       rel_take
);

  logic sgn_lt;

  always_comb begin
    sgn_lt   = cc.neg ^ cc.ovf;
    is_loop  = (op_hi[7:1] == LOOP_PREFIX);
    is_rel   = 1'b1;
    rel_take = 1'b0;
    case (op_hi)
      OP_ALWAYS: rel_take = 1'b1;
      OP_NE:     rel_take = !cc.zer;
      OP_EQ:     rel_take = cc.zer;
      OP_GE:     rel_take = !sgn_lt;
      OP_LT:     rel_take = sgn_lt;
      OP_GT:     rel_take = !(cc.zer | sgn_lt);
      OP_LE:     rel_take = cc.zer | sgn_lt;
      OP_PL:     rel_take = !cc.neg;
      OP_MI:     rel_take = cc.neg;
      OP_HI:     rel_take = !(cc.cry | cc.zer);
      OP_LOS:    rel_take = cc.cry | cc.zer;
      OP_VC:     rel_take = !cc.ovf;
      OP_VS:     rel_take = cc.ovf;
      OP_CC:     rel_take = !cc.cry;
      OP_CS:     rel_take = cc.cry;
      default: begin
        is_rel   = 1'b0;
        rel_take = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/branch_target.sv
module branch_target #(
  parameter int ADDR_W  = 16,
  parameter int REL_W   = 8,
  parameter int LOOP_W  = 6
) (
  input  logic [ADDR_W-1:0] base_pc,
  input  logic [REL_W-1:0]  rel_ofs,
  input  logic [LOOP_W-1:0] loop_ofs,
  input  logic              sel_loop,
  output logic [ADDR_W-1:0] dest
);

  localparam int REL_PAD  = ADDR_W - REL_W;
  localparam int LOOP_PAD = ADDR_W - LOOP_W;

  logic [ADDR_W-1:0] rel_ext;
  logic [ADDR_W-1:0] loop_ext;
  logic [ADDR_W-1:0] fwd_sum;
  logic [ADDR_W-1:0] back_sum;

  always_comb begin
    rel_ext  = {{REL_PAD{rel_ofs[REL_W-1]}}, rel_ofs};
    loop_ext = {{LOOP_PAD{1'b0}}, loop_ofs};
    fwd_sum  = base_pc + {rel_ext[ADDR_W-2:0], 1'b0};
    back_sum = base_pc - {loop_ext[ADDR_W-2:0], 1'b0};
    dest     = sel_loop ? back_sum : fwd_sum;
  end

endmodule

// File: rtl/branch_loopdec.sv
module branch_loopdec #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] cnt_in,
  output logic [DATA_W-1:0] cnt_out,
  output logic              cnt_live
);

  always_comb begin
    cnt_out  = cnt_in - {{(DATA_W-1){1'b0}}, 1'b1};
    cnt_live = |cnt_out;
  end

endmodule

// File: rtl/branch_unit.sv
module branch_unit
  import branch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int INSN_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [INSN_W-1:0] instr,
  input  logic [3:0]        flags,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              res_valid,
  output logic              br_taken,
  output logic [ADDR_W-1:0] br_target,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_data
);

  localparam int REL_W   = 8;
  localparam int LOOP_W  = 6;
  localparam int IDX_LSB = LOOP_W;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  cc_t               cc_in;
  logic              is_loop;
  logic              is_rel;
  logic              rel_take;
  logic [ADDR_W-1:0] dest_c;
  logic [DATA_W-1:0] dec_c;
  logic              dec_live;

  assign cc_in = cc_t'(flags);

  branch_cond u_cond (
    .op_hi    (instr[INSN_W-1 -: 8]),
    .cc       (cc_in),
    .is_loop  (is_loop),
    .is_rel   (is_rel),
    .rel_take (rel_take)
  );

  branch_target #(
    .ADDR_W (ADDR_W),
    .REL_W  (REL_W),
    .LOOP_W (LOOP_W)
  ) u_target (
    .base_pc  (next_pc),
    .rel_ofs  (instr[REL_W-1:0]),
    .loop_ofs (instr[LOOP_W-1:0]),
    .sel_loop (is_loop),
    .dest     (dest_c)
  );

  branch_loopdec #(
    .DATA_W (DATA_W)
  ) u_dec (
    .cnt_in   (reg_rdata),
    .cnt_out  (dec_c),
    .cnt_live (dec_live)
  );

  logic              valid_d, taken_d, wb_en_d;
  logic              valid_q, taken_q, wb_en_q;
  logic [ADDR_W-1:0] target_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;
  logic              dec_take;

  always_comb begin
    dec_take = is_loop & dec_live;
    valid_d  = req_valid;
    taken_d  = req_valid & ((is_rel & rel_take) | dec_take);
    wb_en_d  = req_valid & is_loop;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q  <= 1'b0;
      taken_q  <= 1'b0;
      wb_en_q  <= 1'b0;
      target_q <= '0;
      idx_q    <= '0;
      data_q   <= '0;
    end else begin
      valid_q <= valid_d;
      taken_q <= taken_d;
      wb_en_q <= wb_en_d;
      if (req_valid) begin
        target_q <= dest_c;
        idx_q    <= instr[IDX_LSB +: IDX_W];
        data_q   <= dec_c;
      end
    end
  end

  assign res_valid = valid_q;
  assign br_taken  = taken_q;
  assign br_target = target_q;
  assign wb_en     = wb_en_q;
  assign wb_idx    = idx_q;
  assign wb_data   = data_q;

  a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> res_valid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> (!res_valid && !br_taken && !wb_en));

  a_r7_wb_value: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && instr[INSN_W-1 -: 7] == LOOP_PREFIX)
      |=> (wb_en && wb_data == DATA_W'($past(reg_rdata) - 1'b1)));

  a_r8_loop_decision: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wb_en |-> (br_taken == (wb_data != '0)));

  a_r4_always_taken: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && instr[INSN_W-1 -: 8] == OP_ALWAYS) |=> br_taken);

  a_r9_wb_only_loop: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && instr[INSN_W-1 -: 7] != LOOP_PREFIX) |=> !wb_en);

endmodule

// File: tb/test_branch_unit.sv
`timescale 1ns/1ps
module test_branch_unit;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [15:0] instr;
  logic [3:0]  flags;
  logic [15:0] next_pc;
  logic [15:0] reg_rdata;
  logic        res_valid;
  logic        br_taken;
  logic [15:0] br_target;
  logic        wb_en;
  logic [2:0]  wb_idx;
  logic [15:0] wb_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  branch_unit i_branch_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .instr     (instr),
    .flags     (flags),
    .next_pc   (next_pc),
    .reg_rdata (reg_rdata),
    .res_valid (res_valid),
    .br_taken  (br_taken),
    .br_target (br_target),
    .wb_en     (wb_en),
    .wb_idx    (wb_idx),
    .wb_data   (wb_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit exp_take(input logic [7:0] hi, input logic [3:0] f, input logic [15:0] r);
    logic n, z, v, c;
    logic [15:0] d;
    {n, z, v, c} = f;
    d = r - 16'd1;
    case (hi)
      8'h01: return 1'b1;
      8'h02: return !z;
      8'h03: return z;
      8'h04: return !(n ^ v);
      8'h05: return n ^ v;
      8'h06: return !(z | (n ^ v));
      8'h07: return z | (n ^ v);
      8'h80: return !n;
      8'h81: return n;
      8'h82: return !(c | z);
      8'h83: return c | z;
      8'h84: return !v;
      8'h85: return v;
      8'h86: return !c;
      8'h87: return c;
      8'h7E, 8'h7F: return d != 16'd0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic issue(input logic [15:0] w, input logic [3:0] f, input logic [15:0] pc, input logic [15:0] r);
    instr     = w;
    flags     = f;
    next_pc   = pc;
    reg_rdata = r;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    req_valid = 1'b0;
    instr     = '0;
    flags     = '0;
    next_pc   = '0;
    reg_rdata = '0;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    chk(!res_valid && !br_taken && !wb_en, "R1 in reset", {29'd0, res_valid, br_taken, wb_en}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!res_valid && !br_taken && !wb_en, "R1 after release", {29'd0, res_valid, br_taken, wb_en}, 32'd0);

    // R4 R5 R6 R9 R10: every upper byte against every flag value
    for (int hi = 0; hi < 256; hi++) begin
      for (int f = 0; f < 16; f++) begin
        logic e;
        logic lp;
        e  = exp_take(8'(hi), 4'(f), 16'h0003);
        lp = (hi == 8'h7E) || (hi == 8'h7F);
        issue({8'(hi), 8'h05}, 4'(f), 16'h1000, 16'h0003);
        chk(res_valid, "R2 valid", {31'd0, res_valid}, 32'd1);
        chk(br_taken == e, $sformatf("R4/R5/R6/R9/R10 take hi=%02h f=%0h", hi, f), {31'd0, br_taken}, {31'd0, e});
        chk(wb_en == lp, "R9 wb_en", {31'd0, wb_en}, {31'd0, lp});
      end
    end

    // R3: displacement sweep with wrap
    for (int o = 0; o < 256; o++) begin
      for (int p = 0; p < 2; p++) begin
        logic [15:0] pc;
        logic [15:0] exp_t;
        pc    = (p == 0) ? 16'h0100 : 16'hFFF0;
        exp_t = pc + {{7{o[7]}}, 8'(o), 1'b0};
        issue({8'h01, 8'(o)}, 4'(o), pc, 16'h0);
        chk(br_taken, "R3 taken", {31'd0, br_taken}, 32'd1);
        chk(br_target == exp_t, $sformatf("R3 target ofs=%02h", o), {16'd0, br_target}, {16'd0, exp_t});
      end
    end

    // R7 R8: loop-count form
    for (int k = 0; k < 6; k++) begin
      for (int o = 0; o < 64; o++) begin
        logic [15:0] r;
        logic [15:0] d;
        logic [15:0] exp_t;
        logic [2:0]  ix;
        case (k)
          0: r = 16'h0000;
          1: r = 16'h0001;
          2: r = 16'h0002;
          3: r = 16'h0003;
          4: r = 16'h8000;
          default: r = 16'hFFFF;
        endcase
        d     = r - 16'd1;
        ix    = 3'(o + k);
        exp_t = 16'h2000 - {9'd0, 6'(o), 1'b0};
        issue({7'b0111111, ix, 6'(o)}, 4'(o), 16'h2000, r);
        chk(wb_en, "R7 wb_en", {31'd0, wb_en}, 32'd1);
        chk(wb_idx == ix, "R7 wb_idx", {29'd0, wb_idx}, {29'd0, ix});
        chk(wb_data == d, "R7 wb_data", {16'd0, wb_data}, {16'd0, d});
        chk(br_taken == (d != 0), $sformatf("R8 take r=%04h", r), {31'd0, br_taken}, {31'd0, d != 0});
        if (d != 0)
          chk(br_target == exp_t, "R8 target", {16'd0, br_target}, {16'd0, exp_t});
      end
    end

    // R2: idle cycle after traffic
    issue({8'h01, 8'h00}, 4'h0, 16'h0, 16'h0);
    @(negedge clk);
    chk(!res_valid && !br_taken && !wb_en, "R2 idle", {29'd0, res_valid, br_taken, wb_en}, 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=expired exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule